// File: doc/BRIEF.md
# Four-Channel Cycle-Steal DMA Engine

This block moves data in 8-bit or 16-bit units between a source address and a destination address in a 24-bit byte address space. It has four channels. Each channel owns a source pointer, a destination pointer, a 16-bit down-counter, a reload value and a control word. Software programs these through a small register port. A peripheral then asks for service by pulsing the channel's request line, which is already synchronized to the clock. Every request moves exactly one unit, using bus cycles stolen from the processor through a single request/grant handshake.

A unit transfer takes one arbitration cycle, one read cycle on the source address and one write cycle on the destination address. The engine re-arbitrates only after the write phase, so a higher-priority channel can cut in between two units of a lower one.

A channel runs in one of two modes. In single mode it stops when its counter runs out. In repeat mode the counter is reloaded and the channel stays armed. Each channel has a one-cycle completion pulse. If software asks for both addresses to increment, the engine keeps the destination fixed and flags the mistake.

Top module: `steal_dma`

## Requirements
- R1: When more than one channel is ready in an arbitration cycle, the lowest-numbered channel is served. The priority is fixed: 0, then 1, then 2, then 3.
- R2: Each unit transfer takes three cycles. The first is the grant cycle (idle phase with `bus_gnt` high). Next comes one cycle with `mem_rd` high at the source address. Last comes one cycle with `mem_wr` high at the destination address, driving the data just read. The next arbitration happens no earlier than the cycle after the write, and `mem_rd` and `mem_wr` are never high together.
- R3: Control word (`cfg_sel`=4) bits [4:3] hold the mode: 00 stopped, 01 single, 11 repeat, and 10 behaves as stopped. Writing 00 drops any pending request at once, and no further transfer starts on that channel.
- R4: In single mode the counter (`cfg_sel`=2) drops by one per transfer. The channel serves requests only while the counter is nonzero. When the counter reaches 0, through a transfer or through a register write, the mode field reads back 00.
- R5: In repeat mode, the transfer that takes the counter from 1 to 0 loads the reload value (`cfg_sel`=3) into the counter instead, and the channel stays armed.
- R6: `dma_irq[i]` is high for exactly one cycle. That cycle is the one right after the write phase of the channel-i transfer that took its counter from 1 to 0, in either mode.
- R7: Control bit 0 selects 16-bit units, bit 1 makes the source (`cfg_sel`=0) increment and bit 2 makes the destination (`cfg_sel`=1) increment. An incrementing address advances by 2 for 16-bit units and by 1 for 8-bit units. A fixed address never changes. A 16-bit unit carries its low byte at the lower address.
- R8: When bits 1 and 2 of the control word are both set, the destination is treated as fixed and control bit 5 reads back 1.
- R9: A request pulse on an armed channel is held in a pending flag until the channel is granted, so no request is lost. This holds while other channels are being served, while `bus_gnt` is low, and while the channel's own earlier unit is in flight. Requests to a disarmed channel are ignored.
- R10: All channel registers can be read and written at any time. A counter written while a channel is active decides the next arbitration and the completion event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dma_req | input | 4 | Per-channel synchronized request; each high cycle is one request |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel selected for register read/write |
| cfg_sel | input | 3 | Register select: 0 source, 1 destination, 2 counter, 3 reload, 4 control |
| cfg_wdata | input | 24 | Register write data |
| cfg_rdata | output | 24 | Register read data for `cfg_ch`/`cfg_sel` (combinational) |
| bus_req | output | 1 | Bus request toward the bus owner |
| bus_gnt | input | 1 | Bus grant; sampled in the arbitration cycle |
| mem_addr | output | 24 | Byte address of the current read or write |
| mem_rd | output | 1 | Read phase strobe |
| mem_wr | output | 1 | Write phase strobe |
| mem_wide | output | 1 | Current unit is 16 bits |
| mem_wdata | output | 16 | Write data (low byte only for 8-bit units) |
| mem_rdata | input | 16 | Read data, valid in the read phase |
| dma_irq | output | 4 | Per-channel completion pulse |

## Verification
Four requests pulsed together while the grant is withheld show both the fixed priority order and that pending requests survive a blocked bus. A request that arrives during an in-flight unit shows that service requests are latched rather than dropped. Directed single-mode and repeat-mode runs separate plain stopping from auto-reload, since the counter, the mode bits and the number of completion pulses differ between them. Random runs mix unit size, which pointer increments, counts and base addresses; the final pointers and the last unit moved, checked against a byte-pattern memory, catch stride and byte-order faults.

// File: rtl/steal_dma_pkg.sv
// Package: shared encodings for the cycle-steal DMA engine.
// Assumes: register select codes and the mode field layout are fixed by the
// software-visible map described in the brief.
package steal_dma_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_ONCE = 2'b01,
        MODE_RSV  = 2'b10,
        MODE_LOOP = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        SEL_SRC = 3'd0,
        SEL_DST = 3'd1,
        SEL_CNT = 3'd2,
        SEL_RLD = 3'd3,
        SEL_CTL = 3'd4
    } sel_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;

    localparam int CTL_W = 6;

endpackage

// File: rtl/steal_dma_arb.sv
// Module: fixed-priority picker. Index 0 has the highest priority.
// Assumes: purely combinational; the caller samples the result only in the
// arbitration cycle.
module steal_dma_arb #(
    parameter int NCH = 4,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] ready_i,
    output logic           any_o,
    output logic [IW-1:0]  win_o
);

    // Scan from the lowest priority up so that the lowest ready index remains.
    always_comb begin
        win_o = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (ready_i[i]) win_o = IW'(i);
        end
    end

    // Any channel ready at all.
    assign any_o = |ready_i;

endmodule

// File: rtl/steal_dma_chan.sv
// Module: register set and sequencing state of one DMA channel.
// Assumes: step_i pulses in the write phase of this channel's transfer and
// take_i in its grant cycle. A register write in the same cycle as step_i
// has priority over the update that step_i would make.
module steal_dma_chan
    import steal_dma_pkg::*;
#(
    parameter int AW = 24,
    parameter int CW = 16,
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              cfg_we_i,
    input  logic [2:0]        cfg_sel_i,
    input  logic [AW-1:0]     cfg_wdata_i,
    input  logic              take_i,
    input  logic              step_i,
    output logic [AW-1:0]     src_o,
    output logic [AW-1:0]     dst_o,
    output logic [CW-1:0]     cnt_o,
    output logic [CW-1:0]     rld_o,
    output logic [CTL_W-1:0]  ctl_o,
    output logic              wide_o,
    output logic              ready_o,
    output logic              irq_o
);

    logic [AW-1:0] src_q, dst_q, stride;
    logic [CW-1:0] cnt_q, rld_q;
    logic          wide_q, sinc_q, dinc_q, pend_q, irq_q;
    mode_e         mode_q;
    logic          wr_src, wr_dst, wr_cnt, wr_rld, wr_ctl;
    logic          armed, last, dinc_eff, dir_err;

    assign wr_src   = cfg_we_i && (cfg_sel_i == SEL_SRC);
    assign wr_dst   = cfg_we_i && (cfg_sel_i == SEL_DST);
    assign wr_cnt   = cfg_we_i && (cfg_sel_i == SEL_CNT);
    assign wr_rld   = cfg_we_i && (cfg_sel_i == SEL_RLD);
    assign wr_ctl   = cfg_we_i && (cfg_sel_i == SEL_CTL);
    assign dir_err  = sinc_q & dinc_q;
    assign dinc_eff = dinc_q & ~sinc_q;
    assign stride   = wide_q ? AW'(DW / 8) : AW'(1);
    assign last     = (cnt_q == CW'(1));
    assign armed    = ((mode_q == MODE_ONCE) && (cnt_q != '0)) || (mode_q == MODE_LOOP);

    // Source pointer: a register write wins over post-transfer stepping.
    always_ff @(posedge clk) begin
        if (!rst_n)                src_q <= '0;
        else if (wr_src)           src_q <= cfg_wdata_i;
        else if (step_i && sinc_q) src_q <= src_q + stride;
    end

    // Destination pointer: steps only if the source is not also incrementing.
    always_ff @(posedge clk) begin
        if (!rst_n)                  dst_q <= '0;
        else if (wr_dst)             dst_q <= cfg_wdata_i;
        else if (step_i && dinc_eff) dst_q <= dst_q + stride;
    end

    // Transfer counter: count down; on the last unit reload (repeat) or clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (wr_cnt) cnt_q <= cfg_wdata_i[CW-1:0];
        else if (step_i) cnt_q <= last ? ((mode_q == MODE_LOOP) ? rld_q : '0) : cnt_q - CW'(1);
    end

    // Reload value register.
    always_ff @(posedge clk) begin
        if (!rst_n)      rld_q <= '0;
        else if (wr_rld) rld_q <= cfg_wdata_i[CW-1:0];
    end

    // Control fields; single mode drops to stopped when the counter empties.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wide_q <= 1'b0;
            sinc_q <= 1'b0;
            dinc_q <= 1'b0;
            mode_q <= MODE_OFF;
        end else if (wr_ctl) begin
            wide_q <= cfg_wdata_i[0];
            sinc_q <= cfg_wdata_i[1];
            dinc_q <= cfg_wdata_i[2];
            mode_q <= mode_e'(cfg_wdata_i[4:3]);
        end else if (mode_q == MODE_ONCE) begin
            if (wr_cnt && (cfg_wdata_i[CW-1:0] == '0)) mode_q <= MODE_OFF;
            else if (!wr_cnt && step_i && last)        mode_q <= MODE_OFF;
        end
    end

    // Pending request flag: set by a request, cleared when granted or disarmed.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_q <= 1'b0;
        else if (!armed) pend_q <= 1'b0;
        else if (req_i)  pend_q <= 1'b1;
        else if (take_i) pend_q <= 1'b0;
    end

    // Completion pulse: registered so it follows the write phase by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= step_i && last && !wr_cnt;
    end

    assign src_o   = src_q;
    assign dst_o   = dst_q;
    assign cnt_o   = cnt_q;
    assign rld_o   = rld_q;
    assign ctl_o   = {dir_err, mode_q, dinc_q, sinc_q, wide_q};
    assign wide_o  = wide_q;
    assign ready_o = pend_q & armed;
    assign irq_o   = irq_q;

    // R3: writing the stopped mode leaves nothing to serve on the next cycle.
    assert_stop_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && (cfg_wdata_i[4:3] == 2'b00)) |=> !ready_o);

    // R4: the last single-mode unit clears the counter, stops and signals.
    assert_single_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && last && (mode_q == MODE_ONCE) && !cfg_we_i)
        |=> ((mode_q == MODE_OFF) && (cnt_q == '0) && !ready_o && irq_o));

    // R5: the last repeat-mode unit reloads the counter and keeps the mode.
    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && last && (mode_q == MODE_LOOP) && !cfg_we_i)
        |=> ((cnt_q == $past(rld_q)) && (mode_q == MODE_LOOP) && irq_o));

    // R6: the completion pulse never lasts two cycles.
    assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R8: with both increment bits set, only the source moves.
    assert_dst_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && sinc_q && dinc_q && !cfg_we_i)
        |=> ($stable(dst_o) && (src_o != $past(src_o))));

endmodule

// File: rtl/steal_dma.sv
// Module: four-channel cycle-steal DMA engine top.
// Assumes: memory read data is valid in the read phase with no wait states;
// the bus grant is held high by the bus owner for the three phases once given.
module steal_dma
    import steal_dma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 24,
    parameter int CW  = 16,
    parameter int DW  = 16,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int BW = DW / 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] dma_req,
    input  logic           cfg_we,
    input  logic [IW-1:0]  cfg_ch,
    input  logic [2:0]     cfg_sel,
    input  logic [AW-1:0]  cfg_wdata,
    output logic [AW-1:0]  cfg_rdata,
    output logic           bus_req,
    input  logic           bus_gnt,
    output logic [AW-1:0]  mem_addr,
    output logic           mem_rd,
    output logic           mem_wr,
    output logic           mem_wide,
    output logic [DW-1:0]  mem_wdata,
    input  logic [DW-1:0]  mem_rdata,
    output logic [NCH-1:0] dma_irq
);

    logic [AW-1:0]    src_a [NCH];
    logic [AW-1:0]    dst_a [NCH];
    logic [CW-1:0]    cnt_a [NCH];
    logic [CW-1:0]    rld_a [NCH];
    logic [CTL_W-1:0] ctl_a [NCH];
    logic [NCH-1:0]   wide_v, ready_v, take_v, step_v;
    logic             any_w;
    logic [IW-1:0]    win_w, cur_q;
    logic [DW-1:0]    data_q;
    logic [NCH-1:0]   lower_mask;
    phase_e           phase_q;

    // One channel instance per request line.
    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign take_v[g] = (phase_q == PH_IDLE) && bus_gnt && any_w && (win_w == IW'(g));
        assign step_v[g] = (phase_q == PH_WRITE) && (cur_q == IW'(g));
        steal_dma_chan #(.AW(AW), .CW(CW), .DW(DW)) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .req_i      (dma_req[g]),
            .cfg_we_i   (cfg_we && (cfg_ch == IW'(g))),
            .cfg_sel_i  (cfg_sel),
            .cfg_wdata_i(cfg_wdata),
            .take_i     (take_v[g]),
            .step_i     (step_v[g]),
            .src_o      (src_a[g]),
            .dst_o      (dst_a[g]),
            .cnt_o      (cnt_a[g]),
            .rld_o      (rld_a[g]),
            .ctl_o      (ctl_a[g]),
            .wide_o     (wide_v[g]),
            .ready_o    (ready_v[g]),
            .irq_o      (dma_irq[g])
        );
    end

    steal_dma_arb #(.NCH(NCH)) u_arb (
        .ready_i(ready_v),
        .any_o  (any_w),
        .win_o  (win_w)
    );

    // Transfer sequencer: grant -> read -> write, then back to arbitration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cur_q   <= '0;
            data_q  <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: if (any_w && bus_gnt) begin
                    cur_q   <= win_w;
                    phase_q <= PH_READ;
                end
                PH_READ: begin
                    data_q  <= wide_v[cur_q] ? mem_rdata : {{(DW-BW){1'b0}}, mem_rdata[BW-1:0]};
                    phase_q <= PH_WRITE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Bus-side outputs decoded from the current phase.
    always_comb begin
        bus_req   = (phase_q != PH_IDLE) || any_w;
        mem_rd    = (phase_q == PH_READ);
        mem_wr    = (phase_q == PH_WRITE);
        mem_wide  = wide_v[cur_q];
        mem_wdata = data_q;
        case (phase_q)
            PH_READ:  mem_addr = src_a[cur_q];
            PH_WRITE: mem_addr = dst_a[cur_q];
            default:  mem_addr = '0;
        endcase
    end

    // Register read mux.
    always_comb begin
        case (sel_e'(cfg_sel))
            SEL_SRC: cfg_rdata = src_a[cfg_ch];
            SEL_DST: cfg_rdata = dst_a[cfg_ch];
            SEL_CNT: cfg_rdata = AW'(cnt_a[cfg_ch]);
            SEL_RLD: cfg_rdata = AW'(rld_a[cfg_ch]);
            SEL_CTL: cfg_rdata = AW'(ctl_a[cfg_ch]);
            default: cfg_rdata = '0;
        endcase
    end

    assign lower_mask = (NCH'(1) << cur_q) - NCH'(1);

    // R1: the granted channel was ready and no lower index was ready.
    assert_fixed_prio_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_q == PH_IDLE) && bus_gnt && any_w)
        |=> (((($past(ready_v) >> cur_q) & NCH'(1)) == NCH'(1)) && (($past(ready_v) & lower_mask) == '0)));

    // R2: a read phase is always followed by the write phase.
    assert_read_then_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> mem_wr);

    // R2: every write phase was preceded by a read phase.
    assert_write_after_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> $past(mem_rd));

    // R2: a write phase is followed by an arbitration cycle, and phases never overlap.
    assert_rearb_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (!mem_rd && !mem_wr));

    // R2: read and write strobes are mutually exclusive.
    assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mem_rd, mem_wr}) <= 1);

endmodule

// File: tb/steal_dma_bench.sv
`timescale 1ns/100ps
module steal_dma_bench;
    localparam int NCH = 4;
    localparam int AW  = 24;
    localparam int DW  = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] dma_req = '0;
    logic           cfg_we = 1'b0;
    logic [1:0]     cfg_ch = '0;
    logic [2:0]     cfg_sel = '0;
    logic [AW-1:0]  cfg_wdata = '0;
    logic [AW-1:0]  cfg_rdata;
    logic           bus_req, bus_gnt = 1'b1;
    logic [AW-1:0]  mem_addr;
    logic           mem_rd, mem_wr, mem_wide;
    logic [DW-1:0]  mem_wdata, mem_rdata;
    logic [NCH-1:0] dma_irq;

    always #2.5 clk = ~clk;

    steal_dma u_steal_dma (
        .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .cfg_we(cfg_we),
        .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wide(mem_wide), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .dma_irq(dma_irq)
    );

    // Byte memory model, 4 KB window; sources live below 0x800, targets above.
    logic [7:0] mem [0:4095];
    int checks = 0, fails = 0, nwr = 0, cyc = 0, last_wr = -10;
    int gap_err = 0, irq_err = 0;
    int irq_cnt [NCH];
    logic [AW-1:0] wr_log [0:1023];
    logic prev_wr = 1'b0, prev_rd = 1'b0;
    bit done = 0;

    function automatic logic [7:0] pat(int a);
        return 8'((a * 7 + 3) ^ (a >> 8));
    endfunction

    function automatic logic [23:0] ctl(bit wide, bit sinc, bit dinc, logic [1:0] mode);
        return {19'd0, mode, dinc, sinc, wide};
    endfunction

    function automatic int moved(int base, bit inc, int n, bit wide);
        return base + (inc ? n * (wide ? 2 : 1) : 0);
    endfunction

    assign mem_rdata = mem_wide ? {mem[mem_addr[11:0] + 12'd1], mem[mem_addr[11:0]]}
                                : {8'h00, mem[mem_addr[11:0]]};

    // Monitor away from the active edge: memory writes, write log, timing.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (mem_wr) begin
                mem[mem_addr[11:0]] = mem_wdata[7:0];
                if (mem_wide) mem[mem_addr[11:0] + 12'd1] = mem_wdata[15:8];
                if (nwr < 1024) wr_log[nwr] = mem_addr;
                nwr++;
                if (!prev_rd || (cyc - last_wr) < 3) gap_err++;
                last_wr = cyc;
            end
            for (int i = 0; i < NCH; i++) begin
                if (dma_irq[i]) begin
                    irq_cnt[i]++;
                    if (!prev_wr) irq_err++;
                end
            end
        end
        prev_wr = mem_wr;
        prev_rd = mem_rd;
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(int ch, int sel, logic [23:0] d);
        @(negedge clk);
        cfg_ch = 2'(ch); cfg_sel = 3'(sel); cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(int ch, int sel, output logic [23:0] d);
        @(negedge clk);
        cfg_ch = 2'(ch); cfg_sel = 3'(sel); cfg_we = 1'b0;
        #1 d = cfg_rdata;
    endtask

    task automatic pulse(logic [3:0] m);
        @(negedge clk);
        dma_req = m;
        @(negedge clk);
        dma_req = '0;
        repeat (6) @(negedge clk);
    endtask

    task automatic setup(int ch, int src, int dst, int cnt, int rld, logic [23:0] c);
        wr(ch, 0, 24'(src)); wr(ch, 1, 24'(dst)); wr(ch, 2, 24'(cnt));
        wr(ch, 3, 24'(rld)); wr(ch, 4, c);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [23:0] v;
        int base, i0, n0;
        void'($urandom(32'd4242));
        for (int i = 0; i < NCH; i++) irq_cnt[i] = 0;
        for (int a = 0; a < 4096; a++) mem[a] = pat(a);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Reset state.
        rd(0, 2, v); chk("R4 reset counter", v, 0);
        rd(0, 4, v); chk("R3 reset mode stopped", v, 0);
        chk("R2 reset bus_req", bus_req, 0);
        chk("R6 reset irq", dma_irq, 0);

        // Single mode, 8-bit, source increments, destination fixed.
        setup(1, 'h100, 'h800, 3, 0, ctl(0, 1, 0, 2'b01));
        n0 = nwr;
        repeat (3) pulse(4'b0010);
        chk("R4 single three units", nwr - n0, 3);
        chk("R7 last byte at fixed dst", mem['h800], pat('h102));
        rd(1, 0, v); chk("R7 src stepped by 1", v, 'h103);
        rd(1, 1, v); chk("R7 dst fixed", v, 'h800);
        rd(1, 2, v); chk("R4 counter empty", v, 0);
        rd(1, 4, v); chk("R4 mode back to 00", v[4:3], 0);
        chk("R6 one irq in single", irq_cnt[1], 1);
        n0 = nwr;
        pulse(4'b0010);
        chk("R9 request to stopped channel ignored", nwr - n0, 0);

        // 16-bit units, source fixed, destination increments.
        setup(2, 'h200, 'h900, 2, 0, ctl(1, 0, 1, 2'b01));
        repeat (2) pulse(4'b0100);
        rd(2, 1, v); chk("R7 dst stepped by 2", v, 'h904);
        chk("R7 word low byte", mem['h902], pat('h200));
        chk("R7 word high byte", mem['h903], pat('h201));
        chk("R7 first word low byte", mem['h900], pat('h200));

        // Priority: all four requested while the grant is held off.
        for (int c = 3; c >= 0; c--) setup(c, 'h300 + c * 16, 'hA00 + c * 16, 1, 0, ctl(0, 1, 0, 2'b01));
        bus_gnt = 1'b0;
        n0 = nwr;
        @(negedge clk); dma_req = 4'hF; @(negedge clk); dma_req = '0;
        repeat (4) @(negedge clk);
        chk("R9 pending held while grant low", nwr - n0, 0);
        chk("R9 bus_req raised", bus_req, 1);
        bus_gnt = 1'b1;
        repeat (20) @(negedge clk);
        for (int k = 0; k < 4; k++) chk("R1 service order", wr_log[n0 + k], 'hA00 + k * 16);

        // Repeat mode with reload.
        setup(3, 'h400, 'hB00, 2, 2, ctl(0, 1, 0, 2'b11));
        i0 = irq_cnt[3];
        repeat (5) pulse(4'b1000);
        chk("R6 two completions in five units", irq_cnt[3] - i0, 2);
        rd(3, 2, v); chk("R5 counter reloaded then stepped", v, 1);
        rd(3, 4, v); chk("R5 still repeat", v[4:3], 2'b11);
        rd(3, 0, v); chk("R7 src after five units", v, 'h405);

        // Stop while a request is pending.
        setup(0, 'h450, 'hB80, 5, 5, ctl(0, 1, 0, 2'b11));
        bus_gnt = 1'b0;
        @(negedge clk); dma_req = 4'h1; @(negedge clk); dma_req = '0;
        wr(0, 4, ctl(0, 1, 0, 2'b00));
        n0 = nwr;
        bus_gnt = 1'b1;
        repeat (8) @(negedge clk);
        chk("R3 stop drops pending", nwr - n0, 0);
        rd(0, 2, v); chk("R3 counter untouched", v, 5);
        wr(0, 4, ctl(0, 1, 0, 2'b10));
        pulse(4'h1);
        chk("R3 reserved mode stays idle", nwr - n0, 0);
        setup(1, 'h460, 'hBC0, 4, 0, ctl(0, 1, 0, 2'b01));
        wr(1, 2, 0);
        rd(1, 4, v); chk("R4 counter write of 0 stops", v[4:3], 0);

        // Both increments: destination held, error flag set.
        setup(2, 'h500, 'hC00, 2, 0, ctl(0, 1, 1, 2'b01));
        rd(2, 4, v); chk("R8 error flag", v[5], 1);
        pulse(4'b0100);
        rd(2, 1, v); chk("R8 dst fixed", v, 'hC00);
        rd(2, 0, v); chk("R8 src moved", v, 'h501);
        chk("R8 data", mem['hC00], pat('h500));

        // Counter rewritten while active.
        setup(1, 'h600, 'hD00, 5, 0, ctl(0, 1, 0, 2'b01));
        pulse(4'b0010);
        rd(1, 2, v); chk("R4 count after one unit", v, 4);
        wr(1, 2, 1);
        i0 = irq_cnt[1];
        pulse(4'b0010);
        chk("R10 rewritten count completes", irq_cnt[1] - i0, 1);
        rd(1, 4, v); chk("R10 stopped after rewrite", v[4:3], 0);

        // Request while the channel's own unit is in flight.
        setup(0, 'h700, 'hE00, 5, 0, ctl(0, 1, 0, 2'b01));
        n0 = nwr;
        @(negedge clk); dma_req = 4'h1; @(negedge clk); dma_req = '0;
        @(negedge clk); dma_req = 4'h1; @(negedge clk); dma_req = '0;
        repeat (10) @(negedge clk);
        chk("R9 in-flight request kept", nwr - n0, 2);
        rd(0, 2, v); chk("R9 counter after two", v, 3);

        // Random runs.
        for (int it = 0; it < 16; it++) begin
            int ch, n, src, dst, sl, dl;
            bit wide, sinc, dinc;
            ch = $urandom % 4; wide = 1'($urandom); sinc = 1'($urandom); dinc = !sinc;
            n = 1 + $urandom % 4; src = $urandom % 'h600; dst = 'h800 + $urandom % 'h600;
            setup(ch, src, dst, n, 0, ctl(wide, sinc, dinc, 2'b01));
            i0 = irq_cnt[ch];
            repeat (n) pulse(4'(1 << ch));
            rd(ch, 0, v); chk("R7 random src", v, moved(src, sinc, n, wide));
            rd(ch, 1, v); chk("R7 random dst", v, moved(dst, dinc, n, wide));
            rd(ch, 4, v); chk("R4 random stop", v[4:3], 0);
            chk("R6 random irq", irq_cnt[ch] - i0, 1);
            sl = moved(src, sinc, n - 1, wide); dl = moved(dst, dinc, n - 1, wide);
            chk("R7 random low byte", mem[dl], pat(sl));
            if (wide) chk("R7 random high byte", mem[dl + 1], pat(sl + 1));
        end

        chk("R2 phase spacing", gap_err, 0);
        chk("R6 irq follows write", irq_err, 0);
        finish_run();
    end
endmodule